// File: doc/BRIEF.md
# Low-Power March Test Precharge Controller

This block decides which SRAM bit-line columns receive a precharge enable while a March-style self test walks the array. In functional operation the access order is unknown, so every column is precharged whenever the global precharge request is high. When a low-power test command is raised, the block relies on the fact that a March element may use any address order it likes. It fixes that order to a complete word line at a time, then restricts precharge to the column being accessed and the one that will be accessed next.

A small address sequencer is part of the block and produces the row and column addresses. The column advances on every step and the row advances only when the column wraps. A direction input chooses ascending or descending order. A load input restarts the walk at the first address for the chosen direction. The walk stops at the final address. The precharge enable vector is decoded from the sequencer's registered address, so a column is enabled one cycle before the sequencer steps onto it.

Top module: `lp_prech_top`

## Requirements
- R1: While reset is held, the address is row 0, column 0. With the precharge request low, all enables are 0.
- R2: With the low-power command low and the precharge request high, every bit of `prech_en` is 1.
- R3: With the precharge request low, every bit of `prech_en` is 0, whatever the mode.
- R4: In low-power mode with the request high and ascending order (`dir_down`=0), exactly two enables are 1: bit `col_addr` and bit `col_addr+1`. This holds away from the last column.
- R5: In low-power mode with the request high and descending order (`dir_down`=1), exactly two enables are 1: bit `col_addr` and bit `col_addr-1`. This holds away from column 0.
- R6: Ascending, at column NUM_COLS-1 of a row that is not the last row, the two enables are bit NUM_COLS-1 and bit 0.
- R7: Descending, at column 0 of a row other than row 0, the two enables are bit 0 and bit NUM_COLS-1.
- R8: In low-power mode at the final address of the walk, only the selected column is enabled. The final address is (NUM_ROWS-1, NUM_COLS-1) ascending and (0, 0) descending.
- R9: When `adv` is 1 and `seq_load` is 0, the address steps to the neighbour column in the chosen direction on each clock edge. The row moves by one in the same direction when the column wraps. At the final address the walk holds. With `adv` 0 and `seq_load` 0 the address does not change.
- R10: With `seq_load` 1, on the next edge the address becomes (0, 0) for ascending or (NUM_ROWS-1, NUM_COLS-1) for descending. This takes priority over `adv`.
- R11: Take a cycle where the low-power command and the request are high and `seq_load` is 0. In the cycle after it, the column then addressed had its enable high in that earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_mode | input | 1 | Low-power test command; 1 restricts precharge |
| prech_req | input | 1 | Global precharge request |
| dir_down | input | 1 | Address order: 0 ascending, 1 descending |
| seq_load | input | 1 | Restart the walk at the first address of the chosen order |
| adv | input | 1 | Step to the next address |
| row_addr | output | ROW_W | Current word line |
| col_addr | output | COL_W | Current column |
| prech_en | output | NUM_COLS | One precharge enable per column |

## Verification
The main function is driven first by directed full walks in both directions, with the low-power command on. These show whether the neighbour enable follows the direction, wraps correctly at row ends, and drops away at the final address. Stretches in functional mode and with the request low separate the all-on and all-off cases from the restricted one. Random runs then mix direction changes in mid-walk, stalls, reloads and mode toggles against a bench model of the address walk. A separate check confirms that each newly addressed column was already enabled in the cycle before. This exposes an enable that lags the address, or one that points the wrong way.

// File: rtl/lp_prech_pkg.sv
package lp_prech_pkg;

  // Column index that follows c in the chosen order, with wrap.
  function automatic int unsigned lp_neighbour(int unsigned c, logic down, int unsigned n);
    if (down) return (c == 0) ? n - 1 : c - 1;
    else      return (c == n - 1) ? 0 : c + 1;
  endfunction

  // True when c is the last column visited in a row for this order.
  function automatic logic lp_row_end(int unsigned c, logic down, int unsigned n);
    return down ? (c == 0) : (c == n - 1);
  endfunction

endpackage

// File: rtl/lp_addr_seq.sv
module lp_addr_seq
  import lp_prech_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 4,
  parameter int unsigned NUM_COLS = 8,
  localparam int unsigned ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic             dir_down,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             at_final
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  logic             row_end;
  logic [COL_W-1:0] col_nx;

  assign row_end  = lp_row_end(32'(col), dir_down, NUM_COLS);
  assign col_nx   = COL_W'(lp_neighbour(32'(col), dir_down, NUM_COLS));
  assign at_final = dir_down ? (row == '0 && col == '0)
                             : (row == LAST_ROW && col == LAST_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (load) begin
      row <= dir_down ? LAST_ROW : '0;
      col <= dir_down ? LAST_COL : '0;
    end else if (adv && !at_final) begin
      col <= col_nx;
      if (row_end) row <= dir_down ? row - 1'b1 : row + 1'b1;
    end
  end
endmodule

// File: rtl/lp_col_sel.sv
module lp_col_sel #(
  parameter int unsigned NUM_COLS = 8,
  localparam int unsigned COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic [COL_W-1:0]    col,
  input  logic                dir_down,
  input  logic                at_final,
  output logic [NUM_COLS-1:0] sel,
  output logic [NUM_COLS-1:0] ahead
);
  for (genvar j = 0; j < NUM_COLS; j++) begin : g_col
    localparam int unsigned UP_SRC = (j + NUM_COLS - 1) % NUM_COLS;
    localparam int unsigned DN_SRC = (j + 1) % NUM_COLS;
    assign sel[j]   = (col == COL_W'(j));
    // Column j is next when its lower (ascending) or upper (descending) neighbour is selected.
    assign ahead[j] = !at_final && (dir_down ? (col == COL_W'(DN_SRC))
                                             : (col == COL_W'(UP_SRC)));
  end
endmodule

// File: rtl/lp_prech_gen.sv
module lp_prech_gen #(
  parameter int unsigned NUM_COLS = 8
) (
  input  logic                lp_mode,
  input  logic                prech_req,
  input  logic [NUM_COLS-1:0] sel,
  input  logic [NUM_COLS-1:0] ahead,
  output logic [NUM_COLS-1:0] prech_en
);
  for (genvar j = 0; j < NUM_COLS; j++) begin : g_en
    assign prech_en[j] = prech_req && (!lp_mode || sel[j] || ahead[j]);
  end
endmodule

// File: rtl/lp_prech_top.sv
module lp_prech_top #(
  parameter int unsigned NUM_ROWS = 4,
  parameter int unsigned NUM_COLS = 8,
  localparam int unsigned ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp_mode,
  input  logic                prech_req,
  input  logic                dir_down,
  input  logic                seq_load,
  input  logic                adv,
  output logic [ROW_W-1:0]    row_addr,
  output logic [COL_W-1:0]    col_addr,
  output logic [NUM_COLS-1:0] prech_en
);
  logic                at_final;
  logic [NUM_COLS-1:0] col_sel;
  logic [NUM_COLS-1:0] col_ahead;

  lp_addr_seq #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) seq_i (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .adv(adv), .dir_down(dir_down),
    .row(row_addr), .col(col_addr), .at_final(at_final)
  );

  lp_col_sel #(.NUM_COLS(NUM_COLS)) sel_i (
    .col(col_addr), .dir_down(dir_down), .at_final(at_final),
    .sel(col_sel), .ahead(col_ahead)
  );

  lp_prech_gen #(.NUM_COLS(NUM_COLS)) gen_i (
    .lp_mode(lp_mode), .prech_req(prech_req), .sel(col_sel), .ahead(col_ahead),
    .prech_en(prech_en)
  );
endmodule

// File: rtl/lp_prech_chk.sv
module lp_prech_chk #(
  parameter int unsigned NUM_ROWS = 4,
  parameter int unsigned NUM_COLS = 8,
  localparam int unsigned ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lp_mode,
  input logic                prech_req,
  input logic                seq_load,
  input logic                adv,
  input logic                at_final,
  input logic [ROW_W-1:0]    row_addr,
  input logic [COL_W-1:0]    col_addr,
  input logic [NUM_COLS-1:0] prech_en
);
  logic                prev_ok;
  logic [NUM_COLS-1:0] prev_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ok <= 1'b0;
      prev_en <= '0;
    end else begin
      prev_ok <= lp_mode && prech_req && !seq_load;
      prev_en <= prech_en;
    end
  end

  assert_all_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prech_req && !lp_mode) |-> (&prech_en));
  assert_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prech_req |-> (prech_en == '0));
  // R4 and R5: never more than two columns in restricted mode
  assert_two_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prech_req && lp_mode) |-> ($countones(prech_en) <= 2));
  assert_sel_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prech_req && lp_mode) |-> prech_en[col_addr]);
  assert_final_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prech_req && lp_mode && at_final) |-> ($countones(prech_en) == 1));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !seq_load) |=> ($stable(row_addr) && $stable(col_addr)));
  assert_ahead_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> prev_en[col_addr]);
endmodule

bind lp_prech_top lp_prech_chk #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) chk_i (
  .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .prech_req(prech_req),
  .seq_load(seq_load), .adv(adv), .at_final(at_final),
  .row_addr(row_addr), .col_addr(col_addr), .prech_en(prech_en)
);

// File: tb/lp_prech_top_tb.sv
module lp_prech_top_tb_top;
  localparam int R = 4;
  localparam int C = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_mode = 1'b0, prech_req = 1'b0, dir_down = 1'b0, seq_load = 1'b0, adv = 1'b0;
  logic [1:0] row_addr;
  logic [2:0] col_addr;
  logic [C-1:0] prech_en;

  int n_chk = 0, n_bad = 0;
  int m_row = 0, m_col = 0;
  string addr_tag = "R1";
  logic [C-1:0] prev_en = '0;
  bit prev_ok = 0;
  int unsigned seed_v;

  always #4 clk = ~clk;

  lp_prech_top dut_i (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .prech_req(prech_req),
    .dir_down(dir_down), .seq_load(seq_load), .adv(adv),
    .row_addr(row_addr), .col_addr(col_addr), .prech_en(prech_en)
  );

  function automatic bit is_final(bit dn, int r, int c);
    if (dn) return (r == 0) && (c == 0);
    return (r == R - 1) && (c == C - 1);
  endfunction

  function automatic logic [C-1:0] exp_en(bit lp, bit req, bit dn, int r, int c);
    logic [C-1:0] v;
    v = '0;
    if (!req) return v;
    if (!lp) return '1;
    v[c] = 1'b1;
    if (!is_final(dn, r, c)) v[dn ? (c + C - 1) % C : (c + 1) % C] = 1'b1;
    return v;
  endfunction

  function automatic string en_tag(bit lp, bit req, bit dn, int r, int c);
    if (!req) return "R3";
    if (!lp) return "R2";
    if (is_final(dn, r, c)) return "R8";
    if (!dn && c == C - 1) return "R6";
    if (dn && c == 0) return "R7";
    return dn ? "R5" : "R4";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive after the edge, check mid-cycle, then advance the model at the edge.
  task automatic cyc(bit lp, bit req, bit dn, bit ld, bit ad);
    logic [C-1:0] e;
    lp_mode = lp; prech_req = req; dir_down = dn; seq_load = ld; adv = ad;
    #2;
    check(addr_tag, "row", int'(row_addr), m_row);
    check(addr_tag, "col", int'(col_addr), m_col);
    e = exp_en(lp, req, dn, m_row, m_col);
    check(en_tag(lp, req, dn, m_row, m_col), "prech_en", int'(prech_en), int'(e));
    if (prev_ok) check("R11", "prev enable of new col", int'(prev_en[col_addr]), 1);
    prev_ok = lp && req && !ld;
    prev_en = prech_en;
    if (ld) begin
      m_row = dn ? R - 1 : 0;
      m_col = dn ? C - 1 : 0;
      addr_tag = "R10";
    end else begin
      addr_tag = "R9";
      if (ad && !is_final(dn, m_row, m_col)) begin
        if (dn) begin
          if (m_col == 0) begin m_col = C - 1; m_row--; end else m_col--;
        end else begin
          if (m_col == C - 1) begin m_col = 0; m_row++; end else m_col++;
        end
      end
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_v = 32'h5eed_0042;
    void'($urandom(seed_v));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "row in reset", int'(row_addr), 0);
    check("R1", "col in reset", int'(col_addr), 0);
    check("R1", "en in reset", int'(prech_en), 0);
    rst_n = 1'b1;
    // full ascending walk with hold at the end
    cyc(1, 1, 0, 1, 0);
    for (int i = 0; i < R * C + 3; i++) cyc(1, 1, 0, 0, 1);
    // full descending walk
    cyc(1, 1, 1, 1, 1);
    for (int i = 0; i < R * C + 3; i++) cyc(1, 1, 1, 0, 1);
    // stalls, functional mode, request off
    cyc(1, 1, 0, 1, 1);
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 6) == 0 ? ~dir_down : dir_down,
          ($urandom % 40) == 0, ($urandom % 5) != 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule